// File: doc/BRIEF.md
# Linked-List Frame Fetch Engine

This block pulls display frame data out of memory for a pixel pipeline. Frame order comes from a chain of descriptors held in memory, not from registers. Each descriptor is four 32-bit words. The engine reads a descriptor as a single four-word burst, then copies the buffer it names into a downstream pixel FIFO in bursts of a size software picks, and then moves to the descriptor that the first word points at. A descriptor that points back at itself refreshes one buffer forever with no help from software. Two descriptors that point at each other alternate between two buffers.

Software uses a two-entry write port. Entry 1 holds the address of the first descriptor. Entry 0 holds the run-enable bit and the burst-size field. The engine raises one-cycle start-of-frame and end-of-frame pulses when a descriptor's command word asks for them. It tags every pushed word with the descriptor's palette bit. It shows the identifier of the current frame on an output. It keeps a sticky flag that records when the display needed a pixel and the FIFO was empty. Memory is reached through one request/grant read port that returns a burst of beats. The FIFO side is a push strobe plus the FIFO's free-space count.

Top module: `frame_fetch_dma`

## Requirements
- R1: When enabled from idle, the engine first requests one burst of length 4 at the descriptor address. It takes the returned beats in this order: next-descriptor address, buffer byte address, frame identifier, command.
- R2: The number of words to transfer is command bits [LEN_W-1:0]. Those words are read from consecutive word addresses starting at the buffer address (byte address plus 4 per word). They are pushed to the FIFO in that order, with the read data unchanged.
- R3: Control bits [29:28] set the burst size: 0 gives 4 words, 1 gives 8, and 2 or 3 give 16. Every data burst of a frame has that size except the last, which is cut down to the words that remain.
- R4: A data burst is requested only when `fifo_space` covers the whole burst plus any word being pushed in that cycle. The FIFO never receives more words than it has room for.
- R5: The next descriptor is requested only after the last data word of the current buffer has been pushed. Its address is the next-descriptor word just fetched. A self-referencing descriptor therefore replays the same buffer.
- R6: If command bit 15 is set, `sof_evt` pulses for one cycle after the descriptor is read and before its first data burst is granted.
- R7: If command bit 16 is set, `eof_evt` pulses for one cycle after the buffer's last word is pushed and before the next descriptor is granted. It never falls in the same cycle as a push.
- R8: `fifo_pal` carries command bit 12 of the current descriptor with every pushed word.
- R9: `frame_id` shows the identifier word of the descriptor fetched most recently.
- R10: A descriptor with length 0 causes no data burst. Its start and end events are still raised, and the engine goes straight on to the next descriptor.
- R11: Clearing the enable bit lets the buffer in progress finish completely. After that no further memory request is made.
- R12: A write to the descriptor-address entry is accepted only while the engine is idle. While fetching, such a write has no effect on the chain.
- R13: `underrun` is set when, in the same cycle, the engine is enabled, `pix_need` is high and `fifo_empty` is high. It stays set until a control write (entry 0) is made in a cycle with no new set condition. It is never set while the engine is disabled.
- R14: After reset, every output is 0: no request, no push, no events, identifier 0, no underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: control (bit 0 enable, bits [29:28] burst), 1: descriptor address |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Read burst request, held until granted |
| mem_addr | output | 32 | Byte address of the burst's first word |
| mem_len | output | 5 | Burst length in words |
| mem_gnt | input | 1 | Grant, one cycle |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |
| fifo_push | output | 1 | Push strobe to the pixel FIFO |
| fifo_wdata | output | 32 | Word pushed |
| fifo_pal | output | 1 | Palette tag for the pushed word |
| fifo_space | input | SPACE_W | Free FIFO entries |
| fifo_empty | input | 1 | FIFO empty |
| pix_need | input | 1 | Display requests a pixel this cycle |
| sof_evt | output | 1 | Start-of-frame pulse |
| eof_evt | output | 1 | End-of-frame pulse |
| frame_id | output | 32 | Identifier of the current descriptor |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench targets lengths that are not a multiple of the burst size. An engine that rounds the last burst up would read past the buffer and push extra words, and the bench would see a length mismatch. It uses zero-length descriptors, self-looping and two-way chains, and a descriptor-address write made in the middle of a run. An engine that fetched the next descriptor early, or that obeyed a late pointer write, would show up as a wrong descriptor address or a push count that does not match at that grant. It drains the FIFO slowly so that space limits the burst issue; an engine that ignores an in-flight push would overfill the FIFO by one word. It also disables the engine in the middle of a frame, and checks the sticky underrun flag both while disabled and after a control write.

// File: rtl/frame_fetch_pkg.sv
package frame_fetch_pkg;
  localparam int WORD_W       = 32;
  localparam int BLEN_W       = 5;
  localparam int DESC_WORDS   = 4;
  localparam int CMD_PAL_BIT  = 12;
  localparam int CMD_SOF_BIT  = 15;
  localparam int CMD_EOF_BIT  = 16;
  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_BURST_LO = 28;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DRECV,
    ST_BWAIT,
    ST_BREQ,
    ST_BRECV,
    ST_FIN
  } ff_state_e;
endpackage

// File: rtl/ffd_ctrl_regs.sv
module ffd_ctrl_regs
  import frame_fetch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              pix_need,
  input  logic              fifo_empty,
  output logic              run_en,
  output logic [1:0]        burst_sel,
  output logic              ptr_wr,
  output logic [WORD_W-1:0] ptr_val,
  output logic              underrun
);
  logic ctl_wr;
  assign ctl_wr  = reg_we && !reg_sel;
  assign ptr_wr  = reg_we && reg_sel;
  assign ptr_val = reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_en    <= 1'b0;
      burst_sel <= 2'd0;
      underrun  <= 1'b0;
    end else begin
      if (ctl_wr) begin
        run_en    <= reg_wdata[CTL_EN_BIT];
        burst_sel <= reg_wdata[CTL_BURST_LO+1:CTL_BURST_LO];
      end
      if (run_en && pix_need && fifo_empty)
        underrun <= 1'b1;
      else if (ctl_wr)
        underrun <= 1'b0;
    end
  end

  a_r13_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
    underrun && !ctl_wr |=> underrun);
  a_r13_no_set_disabled: assert property (@(posedge clk) disable iff (rst)
    !run_en && !underrun |=> !underrun);
endmodule

// File: rtl/ffd_burst_sizer.sv
module ffd_burst_sizer
  import frame_fetch_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic [LEN_W-1:0]  remaining,
  input  logic [1:0]        burst_sel,
  output logic [BLEN_W-1:0] bmax,
  output logic [BLEN_W-1:0] bsz
);
  always_comb begin
    case (burst_sel)
      2'd0:    bmax = BLEN_W'(4);
      2'd1:    bmax = BLEN_W'(8);
      default: bmax = BLEN_W'(16);
    endcase
    if (remaining < LEN_W'(bmax))
      bsz = remaining[BLEN_W-1:0];
    else
      bsz = bmax;
  end
endmodule

// File: rtl/ffd_seq.sv
module ffd_seq
  import frame_fetch_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int SPACE_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_en,
  input  logic [1:0]         burst_sel,
  input  logic               ptr_wr,
  input  logic [WORD_W-1:0]  ptr_val,
  output logic               mem_req,
  output logic [WORD_W-1:0]  mem_addr,
  output logic [BLEN_W-1:0]  mem_len,
  input  logic               mem_gnt,
  input  logic               mem_rvalid,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               fifo_push,
  output logic [WORD_W-1:0]  fifo_wdata,
  output logic               fifo_pal,
  input  logic [SPACE_W-1:0] fifo_space,
  output logic               sof_evt,
  output logic               eof_evt,
  output logic [WORD_W-1:0]  frame_id
);
  localparam int ADDR_PAD = WORD_W - BLEN_W - 2;
  localparam int REM_PAD  = LEN_W - BLEN_W;

  ff_state_e          state;
  logic [BLEN_W-1:0]  cnt;
  logic [BLEN_W-1:0]  cur_len;
  logic [WORD_W-1:0]  desc_ptr;
  logic [WORD_W-1:0]  nxt_ptr;
  logic [WORD_W-1:0]  buf_addr;
  logic [LEN_W-1:0]   rem;
  logic               cmd_eof;
  logic               cmd_pal;
  logic [BLEN_W-1:0]  bmax;
  logic [BLEN_W-1:0]  bsz;
  logic               room_ok;

  ffd_burst_sizer #(.LEN_W(LEN_W)) u_sizer (
    .remaining (rem),
    .burst_sel (burst_sel),
    .bmax      (bmax),
    .bsz       (bsz)
  );

  assign room_ok  = int'(fifo_space) >= (int'(bsz) + int'(fifo_push));
  assign mem_req  = (state == ST_DREQ) || (state == ST_BREQ);
  assign mem_addr = (state == ST_DREQ) ? desc_ptr : buf_addr;
  assign mem_len  = (state == ST_DREQ) ? BLEN_W'(DESC_WORDS) : cur_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      cur_len    <= '0;
      desc_ptr   <= '0;
      nxt_ptr    <= '0;
      buf_addr   <= '0;
      rem        <= '0;
      cmd_eof    <= 1'b0;
      cmd_pal    <= 1'b0;
      fifo_push  <= 1'b0;
      fifo_wdata <= '0;
      fifo_pal   <= 1'b0;
      sof_evt    <= 1'b0;
      eof_evt    <= 1'b0;
      frame_id   <= '0;
    end else begin
      fifo_push <= 1'b0;
      sof_evt   <= 1'b0;
      eof_evt   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ptr_wr) desc_ptr <= ptr_val;
          if (run_en) state <= ST_DREQ;
        end
        ST_DREQ: begin
          if (mem_gnt) begin
            cnt   <= '0;
            state <= ST_DRECV;
          end
        end
        ST_DRECV: begin
          if (mem_rvalid) begin
            cnt <= cnt + 1'b1;
            case (cnt[1:0])
              2'd0: nxt_ptr  <= mem_rdata;
              2'd1: buf_addr <= mem_rdata;
              2'd2: frame_id <= mem_rdata;
              default: begin
                rem     <= mem_rdata[LEN_W-1:0];
                cmd_eof <= mem_rdata[CMD_EOF_BIT];
                cmd_pal <= mem_rdata[CMD_PAL_BIT];
                sof_evt <= mem_rdata[CMD_SOF_BIT];
                state   <= (mem_rdata[LEN_W-1:0] == '0) ? ST_FIN : ST_BWAIT;
              end
            endcase
          end
        end
        ST_BWAIT: begin
          if (room_ok) begin
            cur_len <= bsz;
            state   <= ST_BREQ;
          end
        end
        ST_BREQ: begin
          if (mem_gnt) begin
            cnt      <= '0;
            buf_addr <= buf_addr + {{ADDR_PAD{1'b0}}, cur_len, 2'b00};
            rem      <= rem - {{REM_PAD{1'b0}}, cur_len};
            state    <= ST_BRECV;
          end
        end
        ST_BRECV: begin
          if (mem_rvalid) begin
            fifo_push  <= 1'b1;
            fifo_wdata <= mem_rdata;
            fifo_pal   <= cmd_pal;
            cnt        <= cnt + 1'b1;
            if (cnt == cur_len - 1'b1)
              state <= (rem == '0) ? ST_FIN : ST_BWAIT;
          end
        end
        ST_FIN: begin
          eof_evt  <= cmd_eof;
          desc_ptr <= nxt_ptr;
          state    <= run_en ? ST_DREQ : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_len));
  a_r3_len_bound: assert property (@(posedge clk) disable iff (rst)
    state == ST_BREQ |-> cur_len != '0 && cur_len <= bmax);
  a_r2_beat_bound: assert property (@(posedge clk) disable iff (rst)
    state == ST_BRECV |-> cnt < cur_len);
  a_r7_eof_no_push: assert property (@(posedge clk) disable iff (rst)
    eof_evt |-> !fifo_push);
  a_r6_sof_single: assert property (@(posedge clk) disable iff (rst)
    sof_evt |=> !sof_evt);
endmodule

// File: rtl/frame_fetch_dma.sv
module frame_fetch_dma
  import frame_fetch_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int FIFO_DEPTH = 32,
  localparam int SPACE_W   = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic               reg_sel,
  input  logic [31:0]        reg_wdata,
  output logic               mem_req,
  output logic [31:0]        mem_addr,
  output logic [4:0]         mem_len,
  input  logic               mem_gnt,
  input  logic               mem_rvalid,
  input  logic [31:0]        mem_rdata,
  output logic               fifo_push,
  output logic [31:0]        fifo_wdata,
  output logic               fifo_pal,
  input  logic [SPACE_W-1:0] fifo_space,
  input  logic               fifo_empty,
  input  logic               pix_need,
  output logic               sof_evt,
  output logic               eof_evt,
  output logic [31:0]        frame_id,
  output logic               underrun
);
  logic              run_en;
  logic [1:0]        burst_sel;
  logic              ptr_wr;
  logic [WORD_W-1:0] ptr_val;

  ffd_ctrl_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .pix_need   (pix_need),
    .fifo_empty (fifo_empty),
    .run_en     (run_en),
    .burst_sel  (burst_sel),
    .ptr_wr     (ptr_wr),
    .ptr_val    (ptr_val),
    .underrun   (underrun)
  );

  ffd_seq #(.LEN_W(LEN_W), .SPACE_W(SPACE_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .burst_sel  (burst_sel),
    .ptr_wr     (ptr_wr),
    .ptr_val    (ptr_val),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_len    (mem_len),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .fifo_push  (fifo_push),
    .fifo_wdata (fifo_wdata),
    .fifo_pal   (fifo_pal),
    .fifo_space (fifo_space),
    .sof_evt    (sof_evt),
    .eof_evt    (eof_evt),
    .frame_id   (frame_id)
  );
endmodule

// File: tb/tb_frame_fetch_dma.sv
`timescale 1ns/1ps
module tb_frame_fetch_dma;
  localparam int LEN_W   = 12;
  localparam int DEPTH   = 32;
  localparam int SPACE_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1;
  logic reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic mem_req, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic [4:0] mem_len;
  logic fifo_push, fifo_pal, fifo_empty = 1'b1, pix_need = 1'b0;
  logic [31:0] fifo_wdata, frame_id;
  logic [SPACE_W-1:0] fifo_space = SPACE_W'(DEPTH);
  logic sof_evt, eof_evt, underrun;

  frame_fetch_dma #(.LEN_W(LEN_W), .FIFO_DEPTH(DEPTH)) dut (.*);

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] mem [0:4095];
  logic [31:0] exp_q[$];
  bit exp_pal[$];
  int push_cnt, occ, gnt_wait, beats_left, desc_cnt;
  int sof_cnt, eof_cnt, exp_sof, exp_eof, req_after, r12_hits;
  bit watch_off, r12_watch, prev_sof, prev_eof;
  logic [31:0] baddr, exp_dptr, cur_addr, cur_id, r12_bogus;
  int cur_rem, bmax;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[a[13:2]];
  endfunction

  function automatic int bmax_of(input int sel);
    return (sel == 0) ? 4 : (sel == 1) ? 8 : 16;
  endfunction

  task automatic on_grant();
    if (mem_addr < 32'h800) begin
      logic [31:0] w1, w3;
      int len;
      chk(mem_addr == exp_dptr, "R5", "descriptor address", mem_addr, exp_dptr);
      chk(mem_len == 5'd4, "R1", "descriptor burst length", mem_len, 4);
      chk(push_cnt == exp_q.size(), "R5", "words pushed before next descriptor", push_cnt, exp_q.size());
      chk(sof_cnt == exp_sof, "R6", "sof count at descriptor", sof_cnt, exp_sof);
      chk(eof_cnt == exp_eof, "R7", "eof count at descriptor", eof_cnt, exp_eof);
      if (r12_watch && mem_addr == r12_bogus) r12_hits++;
      w1 = rd(mem_addr + 4);
      w3 = rd(mem_addr + 12);
      cur_id = rd(mem_addr + 8);
      exp_dptr = rd(mem_addr);
      len = int'(w3[LEN_W-1:0]);
      exp_sof += int'(w3[15]);
      exp_eof += int'(w3[16]);
      for (int i = 0; i < len; i++) begin
        exp_q.push_back(rd(w1 + 32'(4 * i)));
        exp_pal.push_back(w3[12]);
      end
      cur_rem = len;
      cur_addr = w1;
      desc_cnt++;
    end else begin
      int bsz;
      if (cur_rem == 0) begin
        chk(1'b0, "R10", "data burst for empty buffer", mem_addr, 0);
        bsz = 0;
      end else begin
        bsz = (cur_rem < bmax) ? cur_rem : bmax;
        chk(mem_len == 5'(bsz), "R3", "data burst length", mem_len, bsz);
        chk(mem_addr == cur_addr, "R2", "data burst address", mem_addr, cur_addr);
        chk(DEPTH - occ >= int'(mem_len), "R4", "space at burst grant", DEPTH - occ, mem_len);
        chk(frame_id == cur_id, "R9", "frame id during transfer", frame_id, cur_id);
        chk(sof_cnt == exp_sof, "R6", "sof before first data", sof_cnt, exp_sof);
      end
      cur_rem -= bsz;
      cur_addr += 32'(4 * bsz);
    end
  endtask

  // memory and FIFO models, driven on the falling edge
  initial begin
    occ = 0; gnt_wait = 0; beats_left = 0;
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
      if (!rst) begin
        if (fifo_push) begin
          if (push_cnt < exp_q.size()) begin
            chk(fifo_wdata == exp_q[push_cnt], "R2", "pushed word", fifo_wdata, exp_q[push_cnt]);
            chk(fifo_pal == exp_pal[push_cnt], "R8", "palette tag", fifo_pal, exp_pal[push_cnt]);
          end else
            chk(1'b0, "R5", "unexpected push", push_cnt, exp_q.size());
          push_cnt++;
          occ++;
          chk(occ <= DEPTH, "R4", "fifo occupancy", occ, DEPTH);
          if (eof_evt) chk(1'b0, "R7", "eof with push", 1, 0);
        end
        if (sof_evt) begin
          sof_cnt++;
          if (prev_sof) chk(1'b0, "R6", "sof wider than a cycle", 2, 1);
        end
        if (eof_evt) begin
          eof_cnt++;
          if (prev_eof) chk(1'b0, "R7", "eof wider than a cycle", 2, 1);
        end
        prev_sof = sof_evt;
        prev_eof = eof_evt;
        if (watch_off && mem_req) req_after++;
        if (occ > 0 && ($urandom % 3 == 0)) occ--;
        mem_rvalid = 1'b0;
        if (mem_gnt) mem_gnt = 1'b0;
        else if (beats_left > 0) begin
          if ($urandom % 4 != 0) begin
            mem_rvalid = 1'b1;
            mem_rdata = rd(baddr);
            baddr += 4;
            beats_left--;
          end
        end else if (mem_req) begin
          if (gnt_wait > 0) gnt_wait--;
          else begin
            on_grant();
            mem_gnt = 1'b1;
            beats_left = int'(mem_len);
            baddr = mem_addr;
            gnt_wait = int'($urandom % 3);
          end
        end
      end
      fifo_space = SPACE_W'(DEPTH - occ);
      fifo_empty = (occ == 0);
    end
  end

  task automatic wr(input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] nx,
                          input logic [31:0] bf, input logic [31:0] id,
                          input logic [31:0] cmd);
    mem[a[13:2]] = nx;
    mem[a[13:2] + 1] = bf;
    mem[a[13:2] + 2] = id;
    mem[a[13:2] + 3] = cmd;
  endtask

  task automatic book_reset(input logic [31:0] ptr, input int sel);
    @(posedge clk);
    push_cnt = 0; exp_q.delete(); exp_pal.delete();
    sof_cnt = 0; eof_cnt = 0; exp_sof = 0; exp_eof = 0; desc_cnt = 0;
    exp_dptr = ptr; bmax = bmax_of(sel); cur_rem = 0;
  endtask

  task automatic start(input logic [31:0] ptr, input int sel);
    book_reset(ptr, sel);
    wr(1'b1, ptr);
    wr(1'b0, (32'(sel) << 28) | 32'h1);
  endtask

  task automatic wait_desc(input int n);
    while (desc_cnt < n) @(negedge clk);
  endtask

  task automatic stop_and_check(input int sel, input string tag);
    int quiet;
    wr(1'b0, 32'(sel) << 28);
    quiet = 0;
    while (quiet < 30) begin
      @(negedge clk); #1;
      if (!mem_req && beats_left == 0 && !mem_gnt) quiet++; else quiet = 0;
    end
    chk(push_cnt == exp_q.size(), "R11", {tag, " frame completed after disable"}, push_cnt, exp_q.size());
    chk(sof_cnt == exp_sof, "R6", {tag, " total sof"}, sof_cnt, exp_sof);
    chk(eof_cnt == exp_eof, "R7", {tag, " total eof"}, eof_cnt, exp_eof);
    chk(frame_id == cur_id, "R9", {tag, " final frame id"}, frame_id, cur_id);
    req_after = 0;
    watch_off = 1'b1;
    repeat (50) @(negedge clk);
    watch_off = 1'b0;
    chk(req_after == 0, "R11", {tag, " requests after stop"}, req_after, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) mem[i] = (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
    book_reset(32'h0, 0);
    repeat (5) @(negedge clk);
    // R14: reset state
    chk(!mem_req && !fifo_push && !sof_evt && !eof_evt, "R14", "idle outputs in reset",
        {mem_req, fifo_push, sof_evt, eof_evt}, 0);
    chk(frame_id == 0 && !underrun, "R14", "id and underrun in reset", {frame_id, underrun}, 0);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!mem_req, "R14", "no request while disabled", mem_req, 0);

    // R1 R2 R3 R5: two-entry chain, burst 4, length 10 ends in a 2-word burst, then self loop
    put_desc(32'h100, 32'h140, 32'h1000, 32'h11, (1 << 15) | (1 << 16) | 10);
    put_desc(32'h140, 32'h140, 32'h1400, 32'h22, (1 << 16) | (1 << 12) | 8);
    start(32'h100, 0);
    wait_desc(4);
    stop_and_check(0, "chain");

    // R10 R12: zero-length descriptor alternating with a 16-word buffer, burst 8
    put_desc(32'h180, 32'h1C0, 32'h0, 32'h33, (1 << 15) | (1 << 16));
    put_desc(32'h1C0, 32'h180, 32'h2000, 32'h44, (1 << 15) | 16);
    start(32'h180, 1);
    wait_desc(2);
    r12_bogus = 32'h100; r12_hits = 0; r12_watch = 1'b1;
    wr(1'b1, 32'h100);
    wait_desc(6);
    r12_watch = 1'b0;
    stop_and_check(1, "zero-length");
    chk(r12_hits == 0, "R12", "pointer write during fetch ignored", r12_hits, 0);

    // R13: underrun flag
    repeat (40) @(negedge clk);
    pix_need = 1'b1;
    repeat (5) @(negedge clk);
    chk(!underrun, "R13", "no underrun while disabled", underrun, 0);
    put_desc(32'h300, 32'h300, 32'h3000, 32'h55, 20);
    start(32'h300, 2);
    repeat (2) @(negedge clk);
    chk(underrun, "R13", "underrun set on empty fifo", underrun, 1);
    pix_need = 1'b0;
    repeat (10) @(negedge clk);
    chk(underrun, "R13", "underrun sticky", underrun, 1);
    wr(1'b0, (32'd2 << 28) | 32'h1);
    @(negedge clk);
    chk(!underrun, "R13", "underrun cleared by control write", underrun, 0);
    wait_desc(3);
    stop_and_check(2, "underrun");

    // random chains
    for (int it = 0; it < 5; it++) begin
      int sel;
      sel = int'($urandom % 4);
      for (int k = 0; k < 3; k++) begin
        logic [31:0] da, nx, cmd;
        da = 32'h400 + 32'(k * 'h40);
        nx = (k < 2) ? da + 32'h40 : (($urandom % 2) ? da : 32'h400);
        cmd = 32'($urandom % 41);
        if ($urandom % 2) cmd[15] = 1'b1;
        if ($urandom % 2) cmd[16] = 1'b1;
        if ($urandom % 2) cmd[12] = 1'b1;
        put_desc(da, nx, 32'h1000 + 32'(k * 'h800), $urandom, cmd);
      end
      start(32'h400, sel);
      wait_desc(6);
      stop_and_check(sel, "random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule